// File: doc/BRIEF.md
# Composable-Control Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit that works on two operands of parameterized width (16 bits by default). It has no opcode decoder. Six independent control inputs each apply one elementary transform:

- clear operand A;
- invert operand A;
- clear operand B;
- invert operand B;
- choose between a sum and a bitwise AND;
- invert the result.

Chaining these transforms produces a family of useful functions. Among them are constants, pass-through, negation, increment, decrement, difference in both directions, AND and OR.

Two status outputs accompany the result. One says that the result is zero. The other says that the result is negative when read as a two's complement number. Arithmetic wraps modulo 2^WIDTH, and no carry or overflow is reported. A datapath places the block between its operand sources and its result sink. It drives the six controls from whatever field of its instruction holds them.

Top module: `bitctl_alu`

## Requirements
- R1: When clr_a is 1, operand A is replaced by all zeros. Inversion by inv_a is applied afterwards, so clr_a=1 with inv_a=1 yields all ones for A.
- R2: Operand B follows the same order: clear by clr_b first, then invert by inv_b.
- R3: When sel_add is 1, the core result is the sum of the conditioned operands modulo 2^WIDTH. The carry out of the top bit is discarded, so 0xFFFF + 0x0001 gives 0x0000.
- R4: When sel_add is 0, the core result is the bitwise AND of the conditioned operands.
- R5: When inv_res is 1, the core result is bitwise inverted before it reaches res.
- R6: res_zero is 1 exactly when every bit of res is 0.
- R7: res_neg equals bit WIDTH-1 of res, which is the two's complement sign.
- R8: The control word {clr_a,inv_a,clr_b,inv_b,sel_add,inv_res} = 6'b001110 yields a - 1.
- R9: The 18 control words listed below, in the bit order of R8, yield the named functions for any operands:
  - constants: 101010 → 0, 111111 → 1, 111010 → -1;
  - pass-through: 001100 → a, 110000 → b;
  - bitwise inversion: 001101 → ~a, 110001 → ~b;
  - negation: 001111 → -a, 110011 → -b;
  - increment: 011111 → a+1, 110111 → b+1;
  - decrement: 001110 → a-1, 110010 → b-1;
  - sum and differences: 000010 → a+b, 010011 → a-b, 000111 → b-a;
  - logic: 000000 → a&b, 010101 → a|b.
- R10: Every one of the 64 control words gives a fully defined result and fully defined flags, as fixed by R1 to R7, with no unknown bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| clr_a | input | 1 | Force operand A to zero |
| inv_a | input | 1 | Bitwise invert operand A, after the clear |
| clr_b | input | 1 | Force operand B to zero |
| inv_b | input | 1 | Bitwise invert operand B, after the clear |
| sel_add | input | 1 | 1 selects the sum, 0 selects the bitwise AND |
| inv_res | input | 1 | Bitwise invert the core result |
| res | output | WIDTH | Result |
| res_zero | output | 1 | Result is zero |
| res_neg | output | 1 | Result sign bit |

## Verification
Every result and both flags settle in the same cycle as the stimulus, because the block holds no register; the result is due zero cycles after its inputs change. The bench changes inputs just after a rising edge of its sampling clock. It reads res, res_zero and res_neg at the following falling edge, half a period later, after all combinational paths have settled. Expected values come from arithmetic written directly in the bench for each named function. The 64-word sweep applies the clear, invert, select and invert-result rules one by one in the bench.

// File: rtl/bitctl_alu_pkg.sv
// Package: shared control-word type for the composable-control ALU.
// Assumes the bit order {clr_a, inv_a, clr_b, inv_b, sel_add, inv_res}.
package bitctl_alu_pkg;
    localparam int CTL_BITS = 6;

    typedef struct packed {
        logic clr_a;
        logic inv_a;
        logic clr_b;
        logic inv_b;
        logic sel_add;
        logic inv_res;
    } alu_ctl_t;
endpackage

// File: rtl/bitctl_operand_cond.sv
// Module: operand conditioning stage.
// Forces the operand to zero when asked, then optionally inverts it.
// Assumes the clear is always applied before the inversion.
module bitctl_operand_cond #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] raw,
    input  logic             clr,
    input  logic             inv,
    output logic [WIDTH-1:0] cond
);
    logic [WIDTH-1:0] cleared;

    // Clear step: replace the operand by zero when requested.
    always_comb cleared = clr ? '0 : raw;

    // Invert step: flip every bit of the cleared value when requested.
    always_comb cond = inv ? ~cleared : cleared;

    // Guard the clear-then-invert order.
    always_comb begin
        // R1
        if (clr && !inv) clear_only_chk: assert (cond == '0)
            else $error("cleared operand not zero");
        // R2
        if (clr && inv) clear_inv_chk: assert (&cond)
            else $error("cleared then inverted operand not all ones");
    end
endmodule

// File: rtl/bitctl_alu_core.sv
// Module: core function stage.
// Selects the sum or the bitwise AND of the conditioned operands, then optionally inverts.
// Assumes the sum wraps modulo 2^WIDTH. RIPPLE=1 builds an explicit carry chain;
// RIPPLE=0 leaves the adder structure to synthesis.
module bitctl_alu_core #(
    parameter int WIDTH  = 16,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sel_add,
    input  logic             inv_res,
    output logic [WIDTH-1:0] res
);
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] conj;
    logic [WIDTH-1:0] core;

    generate
        if (RIPPLE) begin : g_ripple
            logic [WIDTH-1:0] carry;
            assign carry[0] = 1'b0;
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign sum[i] = a[i] ^ b[i] ^ carry[i];
                if (i < WIDTH - 1) begin : g_cy
                    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
                end
            end
        end else begin : g_infer
            assign sum = a + b;
        end
    endgenerate

    // Bitwise AND of the two conditioned operands.
    always_comb conj = a & b;

    // Pick the sum or the AND, then apply the result inversion.
    always_comb begin
        core = sel_add ? sum : conj;
        res  = inv_res ? ~core : core;
    end

    // Guard the sum and AND selections.
    always_comb begin
        // R3
        if (sel_add && !inv_res && (b == '0)) add_identity_chk: assert (res == a)
            else $error("sum with zero changed the operand");
        // R4
        if (!sel_add && !inv_res) and_subset_chk: assert ((res & ~(a & b)) == '0)
            else $error("AND result has bits outside both operands");
        // R5
        if (!sel_add && inv_res) nand_cover_chk: assert ((res | ~(a & b)) == ~(a & b))
            else $error("inverted AND result mismatch");
    end
endmodule

// File: rtl/bitctl_alu_flags.sv
// Module: status flag generator.
// Reports a zero result and a negative two's complement result.
// Assumes the sign is the top bit of the result.
module bitctl_alu_flags #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] res,
    output logic             is_zero,
    output logic             is_neg
);
    localparam int MSB = WIDTH - 1;

    // Reduce the result to its two status bits.
    always_comb begin
        is_zero = ~|res;
        is_neg  = res[MSB];
    end
endmodule

// File: rtl/bitctl_alu.sv
// Module: top of the composable-control ALU.
// Two operand conditioners feed the core stage; the flags follow the result.
// Assumes purely combinational use: it has no clock and no state.
module bitctl_alu #(
    parameter int WIDTH  = 16,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             clr_a,
    input  logic             inv_a,
    input  logic             clr_b,
    input  logic             inv_b,
    input  logic             sel_add,
    input  logic             inv_res,
    output logic [WIDTH-1:0] res,
    output logic             res_zero,
    output logic             res_neg
);
    import bitctl_alu_pkg::*;

    localparam int NUM_OPS = 2;

    alu_ctl_t                      ctl;
    logic [NUM_OPS-1:0][WIDTH-1:0] raw_ops;
    logic [NUM_OPS-1:0][WIDTH-1:0] cond_ops;
    logic [NUM_OPS-1:0]            clr_vec;
    logic [NUM_OPS-1:0]            inv_vec;

    // Gather the control bits and operands into indexed form.
    always_comb begin
        ctl        = '{clr_a: clr_a, inv_a: inv_a, clr_b: clr_b,
                       inv_b: inv_b, sel_add: sel_add, inv_res: inv_res};
        raw_ops[0] = opa;
        raw_ops[1] = opb;
        clr_vec    = {ctl.clr_b, ctl.clr_a};
        inv_vec    = {ctl.inv_b, ctl.inv_a};
    end

    generate
        for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
            bitctl_operand_cond #(.WIDTH(WIDTH)) u_cond (
                .raw  (raw_ops[k]),
                .clr  (clr_vec[k]),
                .inv  (inv_vec[k]),
                .cond (cond_ops[k])
            );
        end
    endgenerate

    bitctl_alu_core #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_core (
        .a       (cond_ops[0]),
        .b       (cond_ops[1]),
        .sel_add (ctl.sel_add),
        .inv_res (ctl.inv_res),
        .res     (res)
    );

    bitctl_alu_flags #(.WIDTH(WIDTH)) u_flags (
        .res     (res),
        .is_zero (res_zero),
        .is_neg  (res_neg)
    );

    // Guard the flags against the result and the decrement encoding.
    always_comb begin
        // R6
        if (res_zero) zero_excl_chk: assert (!res_neg && (res == '0))
            else $error("zero flag with nonzero or negative result");
        // R7
        neg_sign_chk: assert (res_neg == ($signed(res) < 0))
            else $error("negative flag disagrees with sign");
        // R8
        if (ctl == 6'b001110) dec_chk: assert (res == opa - 1'b1)
            else $error("decrement encoding wrong");
        // R10
        if (!$isunknown({opa, opb, ctl})) defined_chk: assert (!$isunknown({res, res_zero, res_neg}))
            else $error("unknown output for known inputs");
    end
endmodule

// File: tb/bitctl_alu_bench.sv
`timescale 1ns/1ps
module bitctl_alu_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic [W-1:0] opa, opb;
    logic [5:0]   ctl;
    logic [W-1:0] res;
    logic         res_zero, res_neg;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    bitctl_alu u_bitctl_alu (
        .opa(opa), .opb(opb),
        .clr_a(ctl[5]), .inv_a(ctl[4]), .clr_b(ctl[3]), .inv_b(ctl[2]),
        .sel_add(ctl[1]), .inv_res(ctl[0]),
        .res(res), .res_zero(res_zero), .res_neg(res_neg)
    );

    // Drive just after a rising edge, sample at the next falling edge.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [5:0] c);
        @(posedge clk);
        #1;
        opa = a; opb = b; ctl = c;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h ctl=%b)", req, act, exp, opa, opb, ctl);
        end
    endtask

    task automatic chk_flags(input string req, input logic [W-1:0] exp);
        chk(req, {14'b0, res_zero, res_neg}, {14'b0, exp == '0, exp[W-1]});
    endtask

    // Composition model: clear, invert, select, invert-result, one step at a time.
    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [5:0] c);
        logic [W-1:0] x, y, r;
        x = c[5] ? '0 : a;  x = c[4] ? ~x : x;
        y = c[3] ? '0 : b;  y = c[2] ? ~y : y;
        r = c[1] ? x + y : x & y;
        return c[0] ? ~r : r;
    endfunction

    task automatic t_idle;
        apply('0, '0, 6'b000000);
        chk("R4 idle result", res, '0);
        chk_flags("R6 idle flags", '0);
    endtask

    task automatic t_clear_order;
        apply(16'h1234, 16'h5678, 6'b100000);
        chk("R1 clear A", res, 16'h0000);
        apply(16'h1234, 16'h5678, 6'b110000);
        chk("R1 clear then invert A", res, 16'h5678);
        apply(16'h1234, 16'h5678, 6'b001100);
        chk("R2 clear then invert B", res, 16'h1234);
    endtask

    task automatic t_add_wrap;
        apply(16'hFFFF, 16'h0001, 6'b000010);
        chk("R3 wrap sum", res, 16'h0000);
        chk_flags("R6 wrap flags", 16'h0000);
        apply(16'h7FFF, 16'h0001, 6'b000010);
        chk("R3 sum into sign", res, 16'h8000);
        chk_flags("R7 sign flag", 16'h8000);
    endtask

    task automatic t_and_inv;
        apply(16'hF0F0, 16'hFF00, 6'b000000);
        chk("R4 AND", res, 16'hF000);
        apply(16'hF0F0, 16'hFF00, 6'b000001);
        chk("R5 invert result", res, 16'h0FFF);
        chk_flags("R7 inverted flags", 16'h0FFF);
    endtask

    task automatic t_decrement;
        apply(16'h0000, 16'h1111, 6'b001110);
        chk("R8 decrement of zero", res, 16'hFFFF);
        apply(16'h8000, 16'h2222, 6'b001110);
        chk("R8 decrement of min", res, 16'h7FFF);
    endtask

    task automatic t_named;
        logic [5:0] codes [18] = '{6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000,
            6'b001101, 6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
            6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101};
        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] a, b, e;
            a = W'($urandom); b = W'($urandom);
            if (n == 0) begin a = 16'h8000; b = 16'h7FFF; end
            for (int k = 0; k < 18; k++) begin
                case (k)
                    0: e = 0;      1: e = 1;      2: e = '1;     3: e = a;
                    4: e = b;      5: e = ~a;     6: e = ~b;     7: e = -a;
                    8: e = -b;     9: e = a + 1;  10: e = b + 1; 11: e = a - 1;
                    12: e = b - 1; 13: e = a + b; 14: e = a - b; 15: e = b - a;
                    16: e = a & b; default: e = a | b;
                endcase
                apply(a, b, codes[k]);
                chk("R9 named function", res, e);
                chk_flags("R9 named flags", e);
            end
        end
    endtask

    task automatic t_all_words;
        for (int c = 0; c < 64; c++) begin
            logic [W-1:0] a, b, e;
            a = W'($urandom); b = W'($urandom);
            e = model(a, b, c[5:0]);
            apply(a, b, c[5:0]);
            checks++;
            if ($isunknown({res, res_zero, res_neg})) begin
                errors++;
                $display("FAIL R10: unknown output %h expected %h", res, e);
            end
            chk("R10 control word", res, e);
            chk_flags("R10 control word flags", e);
        end
    endtask

    initial begin
        opa = '0; opb = '0; ctl = '0;
        t_idle();
        t_clear_order();
        t_add_wrap();
        t_and_inv();
        t_decrement();
        t_named();
        t_all_words();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule